// File: doc/BRIEF.md
# Sleep Entry and Recovery Sequencer

This block sits in front of the control path of a synchronous memory and runs its low-power state. An active-high sleep request arrives with no relation to the clock and is treated as inactive when nothing drives it. The block brings the request into the clock domain, waits a fixed number of clocks, and then puts the memory to sleep. While asleep, every command input is blocked and the data outputs are held off. Stored contents and internal state are untouched.

When the request falls, the block does not return to full operation at once. It first runs a recovery window whose length is a parameter in clock cycles, for example 20 ns divided by the clock period and rounded up. In that window, reads and idle cycles reach the core, but any write is removed from the command path and reported on a one-cycle error output. After the window closes, commands pass through unchanged.

A command is described by a valid bit and a write bit. A cycle with the valid bit low is a deselect.

Top module: `sleep_guard`

## Requirements
- R1: After reset the block is awake. asleep_o, recovering_o, out_off_o and wr_drop_o are 0 and in_gate_o is 1.
- R2: The request passes two synchroniser flops. It must then be seen high on ENTRY_CYCLES (default 2) consecutive edges. With the defaults, asleep_o rises after the fourth rising edge at which sleep_req_i is sampled high without a break.
- R3: If the request drops before sleep is reached, the entry is abandoned. The entry count restarts from zero, so a request high for one edge never causes sleep.
- R4: While asleep_o is 1, in_gate_o is 0, out_off_o is 1, and cmd_valid_o, cmd_write_o and wr_drop_o are 0, whatever the command inputs are.
- R5: Sleep lasts while the synchronised request stays high. After the synchronised request falls, recovering_o is 1 for exactly RECOVER_CYCLES cycles (default 5), and then the block is awake.
- R6: During recovery, a read (cmd_valid_i=1, cmd_write_i=0) appears on cmd_valid_o in the same cycle, and a deselect (cmd_valid_i=0) leaves cmd_valid_o at 0.
- R7: During recovery, a write (cmd_valid_i=1, cmd_write_i=1) is removed: cmd_valid_o is 0 and wr_drop_o is 1 in that same cycle.
- R8: If the synchronised request is seen high during recovery, the block goes back to sleep at that edge, with no entry delay.
- R9: While awake, including during the entry count, cmd_valid_o equals cmd_valid_i, cmd_write_o equals cmd_valid_i AND cmd_write_i, and wr_drop_o is 0.
- R10: asleep_o and recovering_o are never 1 together, and wr_drop_o is 1 only during recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Sleep request, asynchronous, active high |
| cmd_valid_i | input | 1 | Command present this cycle (0 = deselect) |
| cmd_write_i | input | 1 | Command is a write (1) or a read (0) |
| cmd_valid_o | output | 1 | Filtered command valid to the core |
| cmd_write_o | output | 1 | Filtered write flag to the core |
| in_gate_o | output | 1 | Input receivers enabled |
| out_off_o | output | 1 | Force data outputs to high impedance |
| asleep_o | output | 1 | Sleep state active |
| recovering_o | output | 1 | Recovery window active |
| wr_drop_o | output | 1 | Write removed during recovery |

## Verification
Two events can fall in the same cycle. The first is a write that arrives in recovery on the very edge where a renewed request sends the block back to sleep. The second is the last recovery cycle meeting a write. The bench provokes both by raising the request during recovery while writes are held on the command inputs, and by placing a write on the final counted recovery cycle and on the first awake cycle. A behavioural model, built from request history and a phase counter, predicts each cycle. It judges whether the write is dropped with wr_drop_o set, or passed or blocked by the state on the other side of that edge.

// File: rtl/sleep_guard_pkg.sv
package sleep_guard_pkg;
  typedef enum logic [1:0] {
    PH_AWAKE   = 2'd0,
    PH_ASLEEP  = 2'd1,
    PH_RECOVER = 2'd2
  } phase_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_guard_pkg::*;
#(
  parameter int ENTRY_CYCLES   = 2,
  parameter int RECOVER_CYCLES = 5
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_sync_i,
  output phase_e phase_o
);
  localparam int MAX_CNT = max_int(ENTRY_CYCLES, RECOVER_CYCLES);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] ENTRY_LAST   = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] RECOVER_LAST = CNT_W'(RECOVER_CYCLES - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_AWAKE: begin
        if (req_sync_i) begin
          if (cnt_q == ENTRY_LAST) begin
            phase_d = PH_ASLEEP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          cnt_d = '0; // abandoned entry
        end
      end
      PH_ASLEEP: begin
        if (!req_sync_i) begin
          phase_d = PH_RECOVER;
          cnt_d   = '0;
        end
      end
      PH_RECOVER: begin
        if (req_sync_i) begin
          phase_d = PH_ASLEEP; // core still quiet, no entry delay
          cnt_d   = '0;
        end else if (cnt_q == RECOVER_LAST) begin
          phase_d = PH_AWAKE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        phase_d = PH_AWAKE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AWAKE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/sleep_cmd_filter.sv
module sleep_cmd_filter
  import sleep_guard_pkg::*;
(
  input  phase_e phase_i,
  input  logic   cmd_valid_i,
  input  logic   cmd_write_i,
  output logic   cmd_valid_o,
  output logic   cmd_write_o,
  output logic   in_gate_o,
  output logic   out_off_o,
  output logic   wr_drop_o
);
  logic is_sleep, is_recov;

  assign is_sleep = (phase_i == PH_ASLEEP);
  assign is_recov = (phase_i == PH_RECOVER);

  always_comb begin
    cmd_valid_o = cmd_valid_i;
    wr_drop_o   = 1'b0;
    if (is_sleep) begin
      cmd_valid_o = 1'b0;
    end else if (is_recov && cmd_write_i) begin
      cmd_valid_o = 1'b0;
      wr_drop_o   = cmd_valid_i;
    end
  end

  assign cmd_write_o = cmd_valid_o & cmd_write_i;
  assign in_gate_o   = ~is_sleep;
  assign out_off_o   = is_sleep;
endmodule

// File: rtl/sleep_guard.sv
module sleep_guard
  import sleep_guard_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int ENTRY_CYCLES   = 2,
  parameter int RECOVER_CYCLES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic cmd_valid_i,
  input  logic cmd_write_i,
  output logic cmd_valid_o,
  output logic cmd_write_o,
  output logic in_gate_o,
  output logic out_off_o,
  output logic asleep_o,
  output logic recovering_o,
  output logic wr_drop_o
);
  logic   req_sync;
  phase_e phase;

  sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sleep_req_i),
    .q_o   (req_sync)
  );

  sleep_fsm #(
    .ENTRY_CYCLES  (ENTRY_CYCLES),
    .RECOVER_CYCLES(RECOVER_CYCLES)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_sync_i(req_sync),
    .phase_o   (phase)
  );

  sleep_cmd_filter u_filt (
    .phase_i    (phase),
    .cmd_valid_i(cmd_valid_i),
    .cmd_write_i(cmd_write_i),
    .cmd_valid_o(cmd_valid_o),
    .cmd_write_o(cmd_write_o),
    .in_gate_o  (in_gate_o),
    .out_off_o  (out_off_o),
    .wr_drop_o  (wr_drop_o)
  );

  assign asleep_o     = (phase == PH_ASLEEP);
  assign recovering_o = (phase == PH_RECOVER);
endmodule

// File: rtl/sleep_guard_chk.sv
module sleep_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_req_i,
  input logic cmd_valid_i,
  input logic cmd_write_i,
  input logic cmd_valid_o,
  input logic cmd_write_o,
  input logic in_gate_o,
  input logic out_off_o,
  input logic asleep_o,
  input logic recovering_o,
  input logic wr_drop_o
);
  a_r4_sleep_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o |-> (!in_gate_o && out_off_o && !cmd_valid_o && !cmd_write_o && !wr_drop_o));

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(asleep_o && recovering_o));

  a_r7_drop_in_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drop_o |-> (recovering_o && !cmd_valid_o && cmd_valid_i && cmd_write_i));

  a_r6_read_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recovering_o && cmd_valid_i && !cmd_write_i) |-> cmd_valid_o);

  a_r9_awake_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asleep_o && !recovering_o) |-> (cmd_valid_o == cmd_valid_i && !wr_drop_o));

  a_r5_recover_after_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recovering_o) |-> $past(asleep_o));

  a_r2_entry_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(asleep_o) && !$past(recovering_o)) |-> ($past(sleep_req_i, 3) && $past(sleep_req_i, 4)));
endmodule

bind sleep_guard sleep_guard_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sleep_req_i (sleep_req_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_write_i (cmd_write_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_write_o (cmd_write_o),
  .in_gate_o   (in_gate_o),
  .out_off_o   (out_off_o),
  .asleep_o    (asleep_o),
  .recovering_o(recovering_o),
  .wr_drop_o   (wr_drop_o)
);

// File: tb/sleep_guard_tb_top.sv
module sleep_guard_tb_top;
  localparam int ENTRY   = 2;
  localparam int RECOVER = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, cv = 1'b0, cw = 1'b0;
  logic cmd_valid_o, cmd_write_o, in_gate_o, out_off_o, asleep_o, recovering_o, wr_drop_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // model state
  int hist[$];
  int m_ph = 0;  // 0 awake, 1 asleep, 2 recovery
  int m_cnt = 0;

  always #2 clk = ~clk;

  sleep_guard #(.SYNC_STAGES(2), .ENTRY_CYCLES(ENTRY), .RECOVER_CYCLES(RECOVER)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(req), .cmd_valid_i(cv), .cmd_write_i(cw),
    .cmd_valid_o(cmd_valid_o), .cmd_write_o(cmd_write_o), .in_gate_o(in_gate_o),
    .out_off_o(out_off_o), .asleep_o(asleep_o), .recovering_o(recovering_o),
    .wr_drop_o(wr_drop_o)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    logic e_v;
    string t;
    e_v = (m_ph == 1) ? 1'b0 : (m_ph == 2) ? (cv && !cw) : cv;
    t = (m_ph == 0) ? "R9" : (m_ph == 1) ? "R4" : (cv && cw) ? "R7" : "R6";
    check("R2", "asleep_o", asleep_o, m_ph == 1);
    check("R5", "recovering_o", recovering_o, m_ph == 2);
    check(t, "cmd_valid_o", cmd_valid_o, e_v);
    check(t, "cmd_write_o", cmd_write_o, e_v && cw);
    check(t, "in_gate_o", in_gate_o, m_ph != 1);
    check(t, "out_off_o", out_off_o, m_ph == 1);
    check(t, "wr_drop_o", wr_drop_o, (m_ph == 2) && cv && cw);
    check("R10", "sleep_and_recovery", asleep_o && recovering_o, 1'b0);
  endtask

  task automatic advance(input logic r);
    int seen;
    seen = (hist.size() >= 2) ? hist[1] : 0;
    hist.push_front(int'(r));
    if (hist.size() > 4) void'(hist.pop_back());
    case (m_ph)
      0: if (seen != 0) begin
           m_cnt++;
           if (m_cnt == ENTRY) begin m_ph = 1; m_cnt = 0; end
         end else m_cnt = 0;
      1: if (seen == 0) begin m_ph = 2; m_cnt = 0; end
      default: if (seen != 0) begin m_ph = 1; m_cnt = 0; end
               else begin
                 m_cnt++;
                 if (m_cnt == RECOVER) begin m_ph = 0; m_cnt = 0; end
               end
    endcase
  endtask

  task automatic step(input logic r, input logic v, input logic w);
    req = r; cv = v; cw = w;
    #1;
    compare();
    advance(r);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc > 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
    finish_run();
  end

  initial begin
    int rec_len;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1", "asleep_o", asleep_o, 1'b0);
    check("R1", "recovering_o", recovering_o, 1'b0);
    check("R1", "in_gate_o", in_gate_o, 1'b1);
    check("R1", "out_off_o", out_off_o, 1'b0);
    check("R1", "wr_drop_o", wr_drop_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 awake traffic
    for (int i = 0; i < 8; i++) step(1'b0, i[0], i[1]);

    // R3 one-edge pulse aborts entry
    step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b1, i[0]);
      check("R3", "asleep_o_after_pulse", asleep_o, 1'b0);
    end

    // R2 entry then R4 sleep with mixed commands
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, i[0]);
    check("R2", "asleep_o_reached", asleep_o, 1'b1);

    // R5 exit and exact recovery length, R6/R7 filtering
    rec_len = 0;
    for (int i = 0; i < 14; i++) begin
      step(1'b0, (i % 3) != 0, i[0]);
      if (recovering_o) rec_len++;
    end
    check("R5", "recovery_len_is_5", rec_len == RECOVER, 1'b1);

    // back to sleep
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0);
    // exit, then re-request during recovery with writes held (R8 + R7 same cycle)
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    while (!recovering_o) step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    check("R8", "asleep_o_back", asleep_o, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0);

    // write on last recovery cycle and first awake cycle
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, i[0]);

    finish_run();
  end
endmodule